// File: doc/BRIEF.md
# Hashed Page Table Group Walker

This block is a hardware translation walker. It turns a virtual page number into a physical frame number by searching a hashed page table held in memory. It is started by the translation cache on a miss, and its result refills that cache directly, so no software handler takes part. The table is split into groups of eight entry words. A request hashes its page number to a primary group. The walker reads every word of that group, one read per cycle in ascending index order, and compares each word as it comes back. If no entry in the primary group matches, it repeats the scan on a secondary group whose index is the bitwise complement of the primary one. When both groups miss, it raises a page fault.

The controller has five states. `ST_IDLE` accepts a request (transition *accept*). `ST_SCAN_PRI` scans the primary group. When that group ends without a match it takes the *retry* transition to `ST_SCAN_SEC`, which scans the secondary group. When either group ends with a match it takes the *hit* transition to `ST_FILL`. When the secondary group ends without a match it takes the *miss* transition to `ST_FAULT`. Both response states last one cycle and then take the *done* transition back to `ST_IDLE`. A reset sends the walker to `ST_IDLE` from any state.

Each entry word is laid out as {valid, hash-select, tag, frame}. The valid bit is bit 29, hash-select is bit 28, the 16-bit tag is bits 27:12, and the 12-bit frame number is bits 11:0. A read is issued with an address in one cycle, and its word returns on the next cycle.

Top module: `hpt_group_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `fill_valid`, `fault_valid` and `mem_rd_en` are 0. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only in `ST_IDLE`.
- R2: The primary group index is the upper byte of the page number XOR the lower byte. The walker reads the group at address {group, index} with index 0 to 7, one read per cycle, in ascending order, starting in the cycle after acceptance.
- R3: The secondary group index is the bitwise complement of the primary index. It is read only after the primary group ends with no match.
- R4: An entry matches only when bit 29 (valid) is 1, bits 27:12 equal the page number, and bit 28 (hash-select) is 0 while scanning the primary group or 1 while scanning the secondary group.
- R5: Every group that is scanned is read in full, all 8 words, even when a match comes early. When several entries match, the one with the lowest index is returned.
- R6: A primary hit drives `fill_valid` for exactly one cycle, in the 10th cycle after the accepting cycle. In that cycle `fill_pfn` carries bits 11:0 of the matching entry and `fill_vpn` carries the requested page number.
- R7: A secondary hit drives `fill_valid` for one cycle, in the 19th cycle after the accepting cycle, with 16 reads in total.
- R8: A miss in both groups drives `fault_valid` for one cycle, in the 19th cycle after the accepting cycle, with `fault_vpn` set to the request. `fill_valid` stays 0.
- R9: While a walk or its response is in progress, `req_ready` is 0 and `req_valid` has no effect. A request held on the port is accepted only after the walker has returned to `ST_IDLE`.
- R10: A reset during a walk abandons the walk. No response follows, and the walker is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vpn | input | 16 | Requested virtual page number |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 11 | Table word address {group, index} |
| mem_rd_data | input | 30 | Entry word, valid one cycle after the strobe |
| fill_valid | output | 1 | One-cycle pulse: translation found |
| fill_vpn | output | 16 | Page number of the fill |
| fill_pfn | output | 12 | Frame number of the fill |
| fault_valid | output | 1 | One-cycle pulse: no translation in either group |
| fault_vpn | output | 16 | Page number that faulted |

## Verification
The tightest coincidence is a match on the final word of a group. In the same cycle that the last compare finds a match, the group-end decision is made, so the hit must be taken without a retry or a fault. The bench provokes this by placing the only valid match for one page at index 7 of its secondary group. It judges the case by a fill carrying that entry's frame exactly 19 cycles after acceptance, with exactly 16 reads. A second case holds `req_valid` high through the response cycle, so that the end of one walk and the next acceptance fall on neighbouring cycles. The bench checks that the held request is not accepted until the walker is back in idle, and that it then gets its own response.

// File: rtl/wh_pkg.sv
package wh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN_PRI,
        ST_SCAN_SEC,
        ST_FILL,
        ST_FAULT
    } wh_state_e;

endpackage

// File: rtl/wh_hash.sv
module wh_hash #(
    parameter int VPN_W = 16,
    localparam int HW   = VPN_W / 2
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic             use_sec,
    output logic [HW-1:0]    group
);
    logic [HW-1:0] prim;

    always_comb begin
        prim  = vpn[VPN_W-1:HW] ^ vpn[HW-1:0];
        group = use_sec ? ~prim : prim;
    end
endmodule

// File: rtl/wh_entry_match.sv
module wh_entry_match #(
    parameter int VPN_W = 16,
    parameter int PFN_W = 12,
    localparam int EW   = 2 + VPN_W + PFN_W
) (
    input  logic [EW-1:0]    word,
    input  logic [VPN_W-1:0] vpn,
    input  logic             want_sec,
    output logic             hit,
    output logic [PFN_W-1:0] pfn
);
    logic             e_valid;
    logic             e_hsel;
    logic [VPN_W-1:0] e_tag;

    always_comb begin
        e_valid = word[EW-1];
        e_hsel  = word[EW-2];
        e_tag   = word[EW-3 -: VPN_W];
        pfn     = word[PFN_W-1:0];
        hit     = e_valid && (e_hsel == want_sec) && (e_tag == vpn);
    end
endmodule

// File: rtl/wh_seq.sv
module wh_seq #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             cmp_v,
    output logic             last
);
    logic [IDX_W:0]   cnt_q;
    logic [IDX_W-1:0] cmp_idx_q;

    always_comb begin
        rd_en  = run && !cnt_q[IDX_W];
        rd_idx = cnt_q[IDX_W-1:0];
        last   = cmp_v && (&cmp_idx_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cmp_v     <= 1'b0;
            cmp_idx_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            cmp_v <= 1'b0;
        end else begin
            cmp_v <= rd_en;
            if (rd_en) begin
                cnt_q     <= cnt_q + 1'b1;
                cmp_idx_q <= rd_idx;
            end
        end
    end
endmodule

// File: rtl/hpt_group_walker.sv
module hpt_group_walker #(
    parameter int VPN_W = 16,
    parameter int PFN_W = 12,
    parameter int IDX_W = 3,
    localparam int HW   = VPN_W / 2,
    localparam int AW   = HW + IDX_W,
    localparam int EW   = 2 + VPN_W + PFN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [EW-1:0]    mem_rd_data,
    output logic             fill_valid,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             fault_valid,
    output logic [VPN_W-1:0] fault_vpn
);
    import wh_pkg::*;

    wh_state_e state_q, state_d;

    logic [VPN_W-1:0] vpn_q;
    logic             found_q;
    logic [PFN_W-1:0] found_pfn_q;
    logic [PFN_W-1:0] pfn_q;

    logic             accept, in_sec, scanning, clr;
    logic             seq_rd_en, seq_cmp_v, seq_last;
    logic [IDX_W-1:0] seq_rd_idx;
    logic [HW-1:0]    group;
    logic             m_hit, cand, hit_now;
    logic [PFN_W-1:0] m_pfn;

    always_comb begin
        accept   = req_valid && (state_q == ST_IDLE);
        in_sec   = (state_q == ST_SCAN_SEC);
        scanning = (state_q == ST_SCAN_PRI) || in_sec;
        cand     = seq_cmp_v && m_hit;
        hit_now  = found_q || cand;
        clr      = accept || ((state_q == ST_SCAN_PRI) && seq_last && !hit_now);
    end

    wh_hash #(.VPN_W(VPN_W)) u_hash (
        .vpn     (vpn_q),
        .use_sec (in_sec),
        .group   (group)
    );

    wh_entry_match #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_match (
        .word     (mem_rd_data),
        .vpn      (vpn_q),
        .want_sec (in_sec),
        .hit      (m_hit),
        .pfn      (m_pfn)
    );

    wh_seq #(.IDX_W(IDX_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .run    (scanning),
        .rd_en  (seq_rd_en),
        .rd_idx (seq_rd_idx),
        .cmp_v  (seq_cmp_v),
        .last   (seq_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_SCAN_PRI;
            ST_SCAN_PRI: if (seq_last) state_d = hit_now ? ST_FILL : ST_SCAN_SEC;
            ST_SCAN_SEC: if (seq_last) state_d = hit_now ? ST_FILL : ST_FAULT;
            ST_FILL:     state_d = ST_IDLE;
            ST_FAULT:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q       <= '0;
            found_q     <= 1'b0;
            found_pfn_q <= '0;
            pfn_q       <= '0;
        end else begin
            if (accept) vpn_q <= req_vpn;
            if (clr) begin
                found_q <= 1'b0;
            end else if (cand && !found_q) begin
                found_q     <= 1'b1;
                found_pfn_q <= m_pfn;
            end
            if (scanning && seq_last && hit_now)
                pfn_q <= found_q ? found_pfn_q : m_pfn;
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_rd_en   = seq_rd_en;
        mem_rd_addr = {group, seq_rd_idx};
        fill_valid  = (state_q == ST_FILL);
        fill_vpn    = vpn_q;
        fill_pfn    = pfn_q;
        fault_valid = (state_q == ST_FAULT);
        fault_vpn   = vpn_q;
    end
endmodule

// File: rtl/wh_walker_chk.sv
module wh_walker_chk #(
    parameter int VPN_W = 16,
    parameter int PFN_W = 12,
    parameter int IDX_W = 3,
    localparam int HW   = VPN_W / 2,
    localparam int AW   = HW + IDX_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_rd_en,
    input logic [AW-1:0]    mem_rd_addr,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic             fault_valid
);
    logic [HW-1:0] prim;
    logic [HW-1:0] rd_grp;

    always_comb begin
        prim   = fill_vpn[VPN_W-1:HW] ^ fill_vpn[HW-1:0];
        rd_grp = mem_rd_addr[AW-1:IDX_W];
    end

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_no_ready_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || fill_valid || fault_valid) |-> !req_ready);

    a_r2_ascending_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && (mem_rd_addr[IDX_W-1:0] != '0)) |->
            ($past(mem_rd_en) && (mem_rd_addr == AW'($past(mem_rd_addr) + 1'b1))));

    a_r3_group_choice: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ((rd_grp == prim) || (rd_grp == ~prim)));

    a_r6_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (!fill_valid && req_ready));

    a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (!fault_valid && req_ready));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));
endmodule

bind hpt_group_walker wh_walker_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .fill_valid  (fill_valid),
    .fill_vpn    (fill_vpn),
    .fault_valid (fault_valid)
);

// File: tb/test_hpt_group_walker.sv
`timescale 1ns/1ps
module test_hpt_group_walker;
    localparam int VW = 16;
    localparam int PW = 12;
    localparam int AW = 11;
    localparam int EW = 30;
    localparam int NV = 6;

    // vector: {vpn, kind (0 primary hit, 1 secondary hit, 2 fault), frame}
    localparam logic [VW+2+PW-1:0] VEC [NV] = '{
        {16'h1234, 2'd0, 12'hA11},
        {16'h5566, 2'd1, 12'hB22},
        {16'h0F0F, 2'd0, 12'hC44},
        {16'hABCD, 2'd2, 12'h000},
        {16'h7777, 2'd2, 12'h000},
        {16'h0000, 2'd0, 12'hE77}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [VW-1:0] req_vpn = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [EW-1:0] mem_rd_data = '0;
    logic          fill_valid;
    logic [VW-1:0] fill_vpn;
    logic [PW-1:0] fill_pfn;
    logic          fault_valid;
    logic [VW-1:0] fault_vpn;

    logic [EW-1:0] mem [2048];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // response capture
    int            r_lat, r_reads, r_bad, r_rdy;
    logic          r_fill, r_fault;
    logic [VW-1:0] r_vpn;
    logic [PW-1:0] r_pfn;

    hpt_group_walker i_hpt_group_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fault_valid(fault_valid), .fault_vpn(fault_vpn)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 50000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [EW-1:0] mk(input logic v, input logic h,
                                         input logic [VW-1:0] t, input logic [PW-1:0] p);
        return {v, h, t, p};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [VW-1:0] v, input int k);
        logic [7:0] g;
        logic [2:0] ix;
        g  = v[15:8] ^ v[7:0];
        if (k >= 8) g = ~g;
        ix = 3'(k % 8);
        return {g, ix};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // called at the negedge right after the accepting edge
    task automatic wait_resp(input logic [VW-1:0] v);
        r_lat = 1; r_reads = 0; r_bad = 0; r_rdy = 0;
        r_fill = 1'b0; r_fault = 1'b0;
        forever begin
            if (mem_rd_en) begin
                if (r_reads >= 16 || mem_rd_addr != exp_addr(v, r_reads)) r_bad = r_bad + 1;
                r_reads = r_reads + 1;
            end
            if (req_ready) r_rdy = r_rdy + 1;
            if (fill_valid || fault_valid || r_lat > 60) break;
            @(negedge clk);
            r_lat = r_lat + 1;
        end
        r_fill  = fill_valid;
        r_fault = fault_valid;
        r_vpn   = fill_valid ? fill_vpn : fault_vpn;
        r_pfn   = fill_pfn;
    endtask

    initial begin
        for (int a = 0; a < 2048; a++) mem[a] = '0;
        mem[{8'h26, 3'd3}] = mk(1'b1, 1'b0, 16'h1234, 12'hA11);
        mem[{8'hCC, 3'd7}] = mk(1'b1, 1'b1, 16'h5566, 12'hB22);  // last word of secondary group
        mem[{8'h33, 3'd0}] = mk(1'b1, 1'b1, 16'h5566, 12'hBAD);  // wrong hash-select in primary
        mem[{8'h00, 3'd0}] = mk(1'b1, 1'b0, 16'h0000, 12'hE77);
        mem[{8'h00, 3'd1}] = mk(1'b0, 1'b0, 16'h0F0F, 12'hC33);  // invalid
        mem[{8'h00, 3'd5}] = mk(1'b1, 1'b0, 16'h0F0F, 12'hC44);
        mem[{8'h00, 3'd6}] = mk(1'b1, 1'b0, 16'h0F0F, 12'hC55);
        mem[{8'h66, 3'd2}] = mk(1'b1, 1'b0, 16'hABCC, 12'hF01);  // tag off by one
        mem[{8'hFF, 3'd4}] = mk(1'b1, 1'b0, 16'h7777, 12'hD66);  // primary select in secondary

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(fill_valid === 1'b0 && fault_valid === 1'b0 && mem_rd_en === 1'b0,
            "R1 quiet after reset", {fill_valid, fault_valid, mem_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            logic [1:0]    kind;
            logic [PW-1:0] pf;
            int            elat, erd;
            v    = VEC[i][VW+2+PW-1 -: VW];
            kind = VEC[i][PW+1:PW];
            pf   = VEC[i][PW-1:0];
            elat = (kind == 2'd0) ? 10 : 19;
            erd  = (kind == 2'd0) ? 8 : 16;
            req_valid = 1'b1; req_vpn = v;
            @(negedge clk);
            req_valid = 1'b0;
            wait_resp(v);
            chk(r_bad == 0, "R2 R3 read addresses", r_bad, 0);
            chk(r_reads == erd, "R5 reads per walk", r_reads, erd);
            chk(r_rdy == 0, "R9 ready low while busy", r_rdy, 0);
            chk(r_vpn == v, "R6 R8 response page", r_vpn, v);
            if (kind == 2'd2) begin
                chk(r_fault && !r_fill, "R8 fault raised", {r_fill, r_fault}, 1);
                chk(r_lat == 19, "R8 fault latency", r_lat, 19);
            end else begin
                chk(r_fill && !r_fault, "R4 R6 R7 fill raised", {r_fill, r_fault}, 2);
                chk(r_pfn == pf, "R4 R5 fill frame", r_pfn, pf);
                chk(r_lat == elat, kind == 2'd0 ? "R6 fill latency" : "R7 fill latency", r_lat, elat);
            end
            @(negedge clk);
            chk(!fill_valid && !fault_valid && req_ready, "R6 one-cycle response",
                {fill_valid, fault_valid, req_ready}, 1);
        end

        // R9: request held through the response; second one changes mid-walk
        req_valid = 1'b1; req_vpn = 16'h1234;
        @(negedge clk);
        req_vpn = 16'h5566;
        wait_resp(16'h1234);
        chk(r_fill && r_vpn == 16'h1234 && r_pfn == 12'hA11, "R9 first request served",
            {r_vpn, r_pfn}, {16'h1234, 12'hA11});
        chk(r_rdy == 0, "R9 held request not taken early", r_rdy, 0);
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 idle before next accept", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_resp(16'h5566);
        chk(r_fill && r_vpn == 16'h5566 && r_pfn == 12'hB22 && r_lat == 19,
            "R9 R7 held request served", {r_vpn, r_pfn, 8'(r_lat)}, {16'h5566, 12'hB22, 8'd19});
        @(negedge clk);

        // R10: reset in the middle of a walk
        req_valid = 1'b1; req_vpn = 16'h5566;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int c = 0; c < 25; c++) begin
                @(negedge clk);
                if (fill_valid || fault_valid || mem_rd_en || !req_ready) seen = seen + 1;
            end
            chk(seen == 0, "R10 walk abandoned on reset", seen, 0);
        end

        // R1 accept still works after the reset
        req_valid = 1'b1; req_vpn = 16'h0000;
        @(negedge clk);
        req_valid = 1'b0;
        wait_resp(16'h0000);
        chk(r_fill && r_pfn == 12'hE77 && r_lat == 10, "R1 R6 walk after reset",
            {r_pfn, 8'(r_lat)}, {12'hE77, 8'd10});
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule